// File: doc/BRIEF.md
# Fast-to-Slow Pulse Handshake Synchronizer

This block moves an event marked by a one-cycle pulse on a fast source clock into a slower destination clock that bears no phase relation to it. A pulse taken in by the source side raises a held request level. That level crosses into the destination domain through a chain of plain flip-flops. The destination turns the rising edge of the synchronized level into a single output pulse, one destination cycle wide. It also returns the level as an acknowledge. The acknowledge crosses back through a second flop chain. When it arrives, the source drops the request. The source then waits for the acknowledge to fall before it takes in another pulse. This is a full four-phase exchange.

The source side shows a busy flag for the whole exchange. A pulse that arrives while busy is high is discarded and causes no output. There is no data path and no back-pressure at the output. The producer treats busy as its ready flag: a pulse is accepted only on a source edge at which busy is low. The destination consumer must take each output pulse on the edge where it is high.

Top module: `pulse_handshake_sync`

## Requirements
- R1: While either reset is high, the flops of that domain are cleared: busy reads 0 once the source reset has been seen, and pulse_out reads 0 once the destination reset has been seen.
- R2: A pulse_in high on a source edge where busy is low is accepted, and busy reads 1 after that edge.
- R3: Once raised, the request stays high until the acknowledge, synchronized into the source domain, reads high.
- R4: On the source edge after the synchronized acknowledge reads high, the request is low.
- R5: A pulse_in that arrives while busy is high is ignored: it raises no new request and adds no output pulse.
- R6: Busy stays high after the request drops and remains high until the synchronized acknowledge has returned low.
- R7: Every pulse_out is exactly one destination clock cycle wide.
- R8: The number of pulse_out pulses equals the number of accepted pulse_in pulses, for clock ratios from 2:1 to 7:1.
- R9: Each crossing passes through SYNC_STAGES (at least 2) flip-flops in the receiving domain. These flops are chained D to Q with no logic between them. The first output pulse appears no later than SYNC_STAGES+2 destination edges after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Fast source clock |
| rst_src | input | 1 | Source reset, active high, synchronous |
| pulse_in | input | 1 | One-cycle event pulse in the source domain |
| busy | output | 1 | High while an exchange is in flight; pulses are dropped while it is high |
| clk_dst | input | 1 | Slow destination clock |
| rst_dst | input | 1 | Destination reset, active high, synchronous |
| pulse_out | output | 1 | One-cycle event pulse in the destination domain |

## Verification
Busy is due one source edge after acceptance, so the bench checks it at the next source falling edge. The output pulse is due two to three destination edges after the request register is set, depending on where the set falls against the destination clock. The bench therefore counts destination falling edges from acceptance and expects the pulse within SYNC_STAGES+2 of them. The round trip has no fixed cycle count, so the bench compares totals only after busy has fallen and a few extra destination cycles have passed. Pulse width is judged by sampling pulse_out on every destination falling edge and flagging any two consecutive high samples.

// File: rtl/psync_pkg.sv
package psync_pkg;
  // Fewest flops allowed on any clock crossing.
  localparam int unsigned PSYNC_MIN_STAGES = 2;

  function automatic int unsigned psync_depth(input int unsigned req);
    return (req < PSYNC_MIN_STAGES) ? PSYNC_MIN_STAGES : req;
  endfunction
endpackage

// File: rtl/psync_flop_chain.sv
module psync_flop_chain
  import psync_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int unsigned N = psync_depth(STAGES);

  logic [N-1:0] chain;

  // Plain D-to-Q shift: no enable, no gating between stages (R9).
  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[N-2:0], d};
  end

  assign q = chain[N-1];
endmodule

// File: rtl/psync_src_side.sv
module psync_src_side #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_in,
  input  logic ack_async,
  output logic req,
  output logic busy
);
  logic ack_seen;

  psync_flop_chain #(.STAGES(STAGES)) u_ack_sync (
    .clk (clk),
    .rst (rst),
    .d   (ack_async),
    .q   (ack_seen)
  );

  logic take;
  assign take = pulse_in && !busy;

  always_ff @(posedge clk) begin
    if (rst)           req <= 1'b0;
    else if (ack_seen) req <= 1'b0;
    else if (take)     req <= 1'b1;
  end

  assign busy = req || ack_seen;

  assert_accept_sets_req_R2: assert property (@(posedge clk) disable iff (rst)
    (pulse_in && !busy) |=> req);
  assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
    (req && !ack_seen) |=> req);
  assert_req_drops_on_ack_R4: assert property (@(posedge clk) disable iff (rst)
    ack_seen |=> !req);
  assert_pulse_ignored_when_busy_R5: assert property (@(posedge clk) disable iff (rst)
    (pulse_in && busy && !req) |=> !req);
  assert_busy_through_drain_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(req) |-> busy);
endmodule

// File: rtl/psync_dst_side.sv
module psync_dst_side #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_async,
  output logic ack,
  output logic pulse_out
);
  logic req_seen;
  logic req_prev;

  psync_flop_chain #(.STAGES(STAGES)) u_req_sync (
    .clk (clk),
    .rst (rst),
    .d   (req_async),
    .q   (req_seen)
  );

  always_ff @(posedge clk) begin
    if (rst) req_prev <= 1'b0;
    else     req_prev <= req_seen;
  end

  assign ack       = req_seen;
  assign pulse_out = req_seen && !req_prev;

  assert_single_cycle_out_R7: assert property (@(posedge clk) disable iff (rst)
    pulse_out |=> !pulse_out);
  assert_no_repeat_while_held_R8: assert property (@(posedge clk) disable iff (rst)
    (ack && $past(ack)) |-> !pulse_out);
endmodule

// File: rtl/pulse_handshake_sync.sv
module pulse_handshake_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_src,
  input  logic rst_src,
  input  logic pulse_in,
  output logic busy,
  input  logic clk_dst,
  input  logic rst_dst,
  output logic pulse_out
);
  logic req_lvl;
  logic ack_lvl;

  psync_src_side #(.STAGES(SYNC_STAGES)) u_src (
    .clk       (clk_src),
    .rst       (rst_src),
    .pulse_in  (pulse_in),
    .ack_async (ack_lvl),
    .req       (req_lvl),
    .busy      (busy)
  );

  psync_dst_side #(.STAGES(SYNC_STAGES)) u_dst (
    .clk       (clk_dst),
    .rst       (rst_dst),
    .req_async (req_lvl),
    .ack       (ack_lvl),
    .pulse_out (pulse_out)
  );
endmodule

// File: tb/sim_pulse_handshake_sync.sv
`timescale 1ns/1ps
module sim_pulse_handshake_sync;
  localparam int unsigned STG = 2;

  logic clk_src = 1'b0;
  logic clk_dst = 1'b0;
  logic rst_src = 1'b1;
  logic rst_dst = 1'b1;
  logic pulse_in = 1'b0;
  logic busy;
  logic pulse_out;
  int   half_dst = 20;

  int checks = 0;
  int errors = 0;
  int out_cnt = 0;
  int wide_cnt = 0;
  logic prev_hi = 1'b0;
  bit   done = 1'b0;

  always #10 clk_src = ~clk_src;           // 50 MHz
  always #(half_dst) clk_dst = ~clk_dst;

  pulse_handshake_sync #(.SYNC_STAGES(STG)) u0 (
    .clk_src(clk_src), .rst_src(rst_src), .pulse_in(pulse_in), .busy(busy),
    .clk_dst(clk_dst), .rst_dst(rst_dst), .pulse_out(pulse_out)
  );

  // Output monitor, sampled away from the active destination edge.
  always @(negedge clk_dst) begin
    if (rst_dst) begin
      prev_hi = 1'b0;
    end else begin
      if (pulse_out) begin
        out_cnt++;
        if (prev_hi) wide_cnt++;
      end
      prev_hi = pulse_out;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input int ratio);
    rst_src = 1'b1; rst_dst = 1'b1;
    half_dst = 10 * ratio;
    repeat (3) @(negedge clk_dst);
    out_cnt = 0; wide_cnt = 0;
    @(negedge clk_src); rst_src = 1'b0;
    @(negedge clk_dst); rst_dst = 1'b0;
    @(negedge clk_src);
  endtask

  // Drive one pulse; returns 1 if busy was low (accepted).
  task automatic send(output bit acc);
    @(negedge clk_src);
    acc = !busy;
    pulse_in = 1'b1;
    @(negedge clk_src);
    pulse_in = 1'b0;
  endtask

  task automatic settle();
    while (busy) @(negedge clk_src);
    repeat (4) @(negedge clk_dst);
  endtask

  // Vector: ratio[15:12], pulse count[11:6], max gap in source cycles[5:0]
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{
    {4'd2, 6'd20, 6'd40}, {4'd3, 6'd20, 6'd50}, {4'd4, 6'd16, 6'd60},
    {4'd5, 6'd16, 6'd63}, {4'd6, 6'd12, 6'd63}, {4'd7, 6'd12, 6'd63},
    {4'd3, 6'd30, 6'd6},  {4'd7, 6'd30, 6'd4}
  };

  initial begin
    #3ms;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit acc;
    int accepted;
    int dropped;
    int lat;

    // R1: reset state with both resets held
    rst_src = 1'b1; rst_dst = 1'b1;
    repeat (3) @(negedge clk_dst);
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    check(pulse_out == 1'b0, "R1 pulse_out in reset", pulse_out, 0);

    // Vector table: ratios 2:1..7:1, random spacing (R8, R7, R5)
    for (int v = 0; v < NV; v++) begin
      do_reset(int'(VEC[v][15:12]));
      accepted = 0; dropped = 0;
      for (int p = 0; p < int'(VEC[v][11:6]); p++) begin
        send(acc);
        if (acc) accepted++; else dropped++;
        repeat ($urandom_range(0, int'(VEC[v][5:0]))) @(negedge clk_src);
      end
      settle();
      check(out_cnt == accepted, "R8 output count equals accepted", out_cnt, accepted);
      check(wide_cnt == 0, "R7 one-cycle output width", wide_cnt, 0);
    end

    // Directed: acceptance, busy timing, latency, drop while busy
    do_reset(4);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    send(acc);
    check(acc == 1'b1, "R2 pulse accepted when idle", acc, 1);
    check(busy == 1'b1, "R2 busy after accept", busy, 1);
    // Second pulse while busy: must be dropped (R5)
    send(acc);
    check(acc == 1'b0, "R5 busy seen at second pulse", acc, 0);
    repeat (2) @(negedge clk_src);
    check(busy == 1'b1, "R3 request still held", busy, 1);
    settle();
    check(out_cnt == 1, "R5 dropped pulse adds no output", out_cnt, 1);
    check(busy == 1'b0, "R4 exchange completes", busy, 0);

    // Latency bound (R9) and busy persistence across drain (R6)
    do_reset(5);
    send(acc);
    lat = 0;
    while (out_cnt == 0 && lat < 20) begin
      @(negedge clk_dst);
      lat++;
    end
    check(lat <= STG + 2, "R9 output latency in destination edges", lat, STG + 2);
    check(busy == 1'b1, "R6 busy while handshake drains", busy, 1);
    settle();
    check(out_cnt == 1 && wide_cnt == 0, "R7 single pulse", out_cnt, 1);

    // Reset in the middle of an exchange returns to idle (R1)
    do_reset(3);
    send(acc);
    rst_src = 1'b1; rst_dst = 1'b1;
    repeat (3) @(negedge clk_dst);
    check(busy == 1'b0, "R1 busy after mid-exchange reset", busy, 0);
    check(pulse_out == 1'b0, "R1 pulse_out after mid-exchange reset", pulse_out, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule